// File: doc/BRIEF.md
# Pulse-Adjusted Trim Setting Controller

This block is the digital core of a single-pin trimming calibrator. Analog comparators outside the block turn one control wire into three level flags: a step-up level, a step-down level and a programming level. The block keeps a setting inside a fixed range (1 to 128 by default) and moves it by one step for each control pulse that is long enough to count. Pulses that are too short are treated as glitches and dropped. Adjustment works only while the enable input is high. After power-up, the very first valid pulse is thrown away, because the comparators may start in an unknown state.

When the programming level is held longer than the programming window, the block commits the current setting to non-volatile storage. It uses a request/acknowledge write handshake and reports busy until the store acknowledges. The stored value is loaded back into the setting in two cases: when power-on reset ends, and whenever the enable input falls. Every timing limit is counted in clock cycles, derived from a clock-frequency parameter.

Top module: `trim_setting_ctrl`

## Requirements
- R1: `setting` is always within SET_MIN..SET_MAX (1..128). A loaded value of 0 becomes 1, and a loaded value above 128 becomes 128.
- R2: A step pulse whose high time is shorter than MIN_PULSE_US (2000 cycles at the default 100 MHz) is ignored. A pulse of at least that length counts on its falling edge.
- R3: After power-on reset, the first qualified step pulse is discarded and later pulses count. A reload caused by the enable input does not re-arm this discard.
- R4: A qualified pulse on `inc_lvl` raises `setting` by exactly one. A qualified pulse on `dec_lvl` lowers it by exactly one.
- R5: Stepping saturates: an up-pulse at 128 leaves 128, and a down-pulse at 1 leaves 1. The setting never wraps.
- R6: While `ce` is low, step pulses are ignored and `setting` does not change.
- R7: `nv_rd_data` is loaded into `setting` (with clamping) on the first cycle after `por_n` rises, and again on every falling edge of the synchronised `ce`.
- R8: Holding `prog_lvl` for more than PROG_HOLD_US (20000 cycles) while `ce` is high raises `nv_wr_req`, with `nv_wr_data` equal to the current setting. A shorter hold, or any hold while `ce` is low, starts no write.
- R9: `nv_wr_req` stays high with stable `nv_wr_data` until `nv_wr_done` is seen. `busy` is high while a write is pending and during the power-up load. Step pulses are ignored while `busy` is high.
- R10: During reset, `setting` = SET_MIN, `busy` = 1 and `nv_wr_req` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low |
| ce | input | 1 | Adjust enable; its falling edge triggers a reload |
| inc_lvl | input | 1 | Step-up comparator level (asynchronous) |
| dec_lvl | input | 1 | Step-down comparator level (asynchronous) |
| prog_lvl | input | 1 | Programming comparator level (asynchronous) |
| nv_rd_data | input | 8 | Value held in non-volatile storage |
| nv_wr_done | input | 1 | Storage write acknowledge |
| setting | output | 8 | Current trim setting |
| busy | output | 1 | Power-up load or storage write in progress |
| nv_wr_req | output | 1 | Storage write request |
| nv_wr_data | output | 8 | Value to be written |

## Verification
A corrupted internal state shows up on `setting`, and it does so at a predictable time. A pulse-width counter that is wrong makes the setting move, or fail to move, about ten cycles after the falling edge of a pulse. A stuck discard flag shows as a missing or extra step on the first or second long pulse after reset. A bad reload path shows within a few cycles of `ce` falling. A write controller in the wrong state shows at once on `busy` and `nv_wr_req`, or later as a wrong value read back after the next enable reload.

// File: rtl/trim_pkg.sv
package trim_pkg;

   function automatic int unsigned clamp_set(int unsigned v, int unsigned lo, int unsigned hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("trim_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/trim_pulse_qual.sv
module trim_pulse_qual #(
   parameter int MIN_CYC = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic hit
);
   localparam int CW = $clog2(MIN_CYC + 1);

   if (MIN_CYC < 1) begin : g_bad_min
      $error("trim_pulse_qual: MIN_CYC must be positive");
   end

   logic [CW-1:0] hi_cnt;
   logic          lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
         lvl_d  <= 1'b0;
      end else begin
         lvl_d <= lvl;
         if (!lvl) hi_cnt <= '0;
         else if (hi_cnt != CW'(MIN_CYC)) hi_cnt <= hi_cnt + CW'(1);
      end
   end

   // trailing edge with a long enough high phase
   assign hit = lvl_d && !lvl && (hi_cnt == CW'(MIN_CYC));
endmodule

// File: rtl/trim_hold_det.sv
module trim_hold_det #(
   parameter int HOLD_CYC = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic fire
);
   localparam int CW = $clog2(HOLD_CYC + 2);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("trim_hold_det: HOLD_CYC must be positive");
   end

   logic [CW-1:0] hold_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_cnt <= '0;
      else if (!lvl) hold_cnt <= '0;
      else if (hold_cnt != CW'(HOLD_CYC + 1)) hold_cnt <= hold_cnt + CW'(1);
   end

   // single strobe on the first high cycle beyond the window
   assign fire = lvl && (hold_cnt == CW'(HOLD_CYC));
endmodule

// File: rtl/trim_setting_ctrl.sv
module trim_setting_ctrl #(
   parameter int CLK_HZ       = 100_000_000,
   parameter int MIN_PULSE_US = 20,
   parameter int PROG_HOLD_US = 200,
   parameter int SET_MIN      = 1,
   parameter int SET_MAX      = 128,
   parameter int SYNC_STAGES  = 2,
   localparam int SET_W       = $clog2(SET_MAX + 1)
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             ce,
   input  logic             inc_lvl,
   input  logic             dec_lvl,
   input  logic             prog_lvl,
   input  logic [SET_W-1:0] nv_rd_data,
   input  logic             nv_wr_done,
   output logic [SET_W-1:0] setting,
   output logic             busy,
   output logic             nv_wr_req,
   output logic [SET_W-1:0] nv_wr_data
);
   localparam int CYC_PER_US = CLK_HZ / 1_000_000;
   localparam int MIN_CYC    = CYC_PER_US * MIN_PULSE_US;
   localparam int HOLD_CYC   = CYC_PER_US * PROG_HOLD_US;

   if (CLK_HZ < 1_000_000 || (CLK_HZ % 1_000_000) != 0) begin : g_bad_clk
      $error("trim_setting_ctrl: CLK_HZ must be a whole number of MHz");
   end
   if (SET_MIN < 1 || SET_MAX <= SET_MIN) begin : g_bad_range
      $error("trim_setting_ctrl: need 1 <= SET_MIN < SET_MAX");
   end
   if (PROG_HOLD_US <= MIN_PULSE_US) begin : g_bad_windows
      $error("trim_setting_ctrl: programming window must exceed pulse minimum");
   end

   logic [3:0] raw_in, syn_in;
   logic       en_s, en_d, prog_s, prog_fire, loading, first_skip;
   logic [1:0] step_lvl, step_hit;
   logic [SET_W-1:0] load_val;

   assign raw_in = {ce, prog_lvl, dec_lvl, inc_lvl};

   trim_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(por_n), .d(raw_in), .q(syn_in)
   );

   assign step_lvl = syn_in[1:0];
   assign prog_s   = syn_in[2];
   assign en_s     = syn_in[3];

   for (genvar g = 0; g < 2; g++) begin : g_qual
      trim_pulse_qual #(.MIN_CYC(MIN_CYC)) u_qual (
         .clk(clk), .rst_n(por_n), .lvl(step_lvl[g]), .hit(step_hit[g])
      );
   end

   trim_hold_det #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk(clk), .rst_n(por_n), .lvl(prog_s), .fire(prog_fire)
   );

   assign load_val = SET_W'(trim_pkg::clamp_set(int'(nv_rd_data), SET_MIN, SET_MAX));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         setting    <= SET_W'(SET_MIN);
         loading    <= 1'b1;
         first_skip <= 1'b1;
         en_d       <= 1'b0;
         nv_wr_req  <= 1'b0;
         nv_wr_data <= '0;
      end else begin
         en_d <= en_s;
         if (loading) begin
            setting <= load_val;
            loading <= 1'b0;
         end else if (en_d && !en_s) begin
            setting <= load_val;
         end else if (en_s && !nv_wr_req && (step_hit[0] ^ step_hit[1])) begin
            if (first_skip) first_skip <= 1'b0;
            else if (step_hit[0]) begin
               if (setting != SET_W'(SET_MAX)) setting <= setting + SET_W'(1);
            end else begin
               if (setting != SET_W'(SET_MIN)) setting <= setting - SET_W'(1);
            end
         end

         if (nv_wr_req) begin
            if (nv_wr_done) nv_wr_req <= 1'b0;
         end else if (!loading && en_s && prog_fire) begin
            nv_wr_req  <= 1'b1;
            nv_wr_data <= setting;
         end
      end
   end

   assign busy = loading || nv_wr_req;
endmodule

// File: rtl/trim_setting_ctrl_chk.sv
module trim_setting_ctrl_chk #(
   parameter int SET_MIN = 1,
   parameter int SET_MAX = 128,
   parameter int SET_W   = 8
) (
   input logic             clk,
   input logic             por_n,
   input logic             en_s,
   input logic             en_d,
   input logic             loading,
   input logic [SET_W-1:0] setting,
   input logic             busy,
   input logic             nv_wr_req,
   input logic             nv_wr_done,
   input logic [SET_W-1:0] nv_wr_data
);
   a_r1_in_range: assert property (@(posedge clk) disable iff (!por_n)
      (setting >= SET_W'(SET_MIN)) && (setting <= SET_W'(SET_MAX)));

   a_r4_unit_step: assert property (@(posedge clk) disable iff (!por_n)
      ($past(en_s) && !$past(loading)) |->
         ((setting == $past(setting)) || (setting == $past(setting) + SET_W'(1))
          || (setting + SET_W'(1) == $past(setting))));

   a_r6_frozen_disabled: assert property (@(posedge clk) disable iff (!por_n)
      ($past(!en_s) && $past(!en_d) && !$past(loading)) |-> $stable(setting));

   a_r9_req_held: assert property (@(posedge clk) disable iff (!por_n)
      (nv_wr_req && !nv_wr_done) |=> nv_wr_req);

   a_r9_data_stable: assert property (@(posedge clk) disable iff (!por_n)
      (nv_wr_req && $past(nv_wr_req)) |-> $stable(nv_wr_data));

   a_r9_busy_on_req: assert property (@(posedge clk) disable iff (!por_n)
      nv_wr_req |-> busy);

   a_r9_no_step_writing: assert property (@(posedge clk) disable iff (!por_n)
      ($past(nv_wr_req) && $past(en_s)) |-> $stable(setting));
endmodule

bind trim_setting_ctrl trim_setting_ctrl_chk #(
   .SET_MIN(SET_MIN), .SET_MAX(SET_MAX), .SET_W(SET_W)
) u_chk (
   .clk(clk), .por_n(por_n), .en_s(en_s), .en_d(en_d), .loading(loading),
   .setting(setting), .busy(busy), .nv_wr_req(nv_wr_req),
   .nv_wr_done(nv_wr_done), .nv_wr_data(nv_wr_data)
);

// File: tb/tb_trim_setting_ctrl.sv
module tb_trim_setting_ctrl;
   localparam int MINC = 2000;
   localparam int HOLD = 20000;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       ce = 1'b0, inc_lvl = 1'b0, dec_lvl = 1'b0, prog_lvl = 1'b0;
   logic [7:0] nv_mem = 8'd100;
   logic       nv_wr_done = 1'b0;
   logic [7:0] setting, nv_wr_data;
   logic       busy, nv_wr_req;

   always #5 clk = ~clk;

   trim_setting_ctrl #(
      .CLK_HZ(100_000_000), .MIN_PULSE_US(20), .PROG_HOLD_US(200),
      .SET_MIN(1), .SET_MAX(128), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .por_n(por_n), .ce(ce), .inc_lvl(inc_lvl), .dec_lvl(dec_lvl),
      .prog_lvl(prog_lvl), .nv_rd_data(nv_mem), .nv_wr_done(nv_wr_done),
      .setting(setting), .busy(busy), .nv_wr_req(nv_wr_req), .nv_wr_data(nv_wr_data)
   );

   typedef struct {
      string      tag;
      logic [7:0] exp_set;
      logic       exp_busy;
      logic       exp_req;
      logic [7:0] exp_wdata;
   } item_t;

   item_t sb[$];
   int n_cmp = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   // monitor: compares queued expectations against the ports
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         n_cmp++;
         if (setting !== it.exp_set || busy !== it.exp_busy || nv_wr_req !== it.exp_req
             || (it.exp_req && nv_wr_data !== it.exp_wdata)) begin
            n_bad++;
            $display("FAIL %s: set=%0d busy=%0b req=%0b wdata=%0d expected set=%0d busy=%0b req=%0b wdata=%0d",
                     it.tag, setting, busy, nv_wr_req, nv_wr_data,
                     it.exp_set, it.exp_busy, it.exp_req, it.exp_wdata);
         end
      end
   end

   task automatic expect_st(string tag, int s, bit b, bit r, int wd);
      item_t it;
      it.tag = tag; it.exp_set = 8'(s); it.exp_busy = b; it.exp_req = r; it.exp_wdata = 8'(wd);
      sb.push_back(it);
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (10) @(negedge clk);
   endtask

   task automatic pulse(bit down, int n);
      @(negedge clk);
      if (down) dec_lvl = 1'b1; else inc_lvl = 1'b1;
      repeat (n) @(negedge clk);
      dec_lvl = 1'b0; inc_lvl = 1'b0;
      settle();
   endtask

   task automatic set_ce(bit v);
      @(negedge clk);
      ce = v;
      settle();
   endtask

   task automatic hold_prog(int n);
      @(negedge clk);
      prog_lvl = 1'b1;
      repeat (n) @(negedge clk);
      prog_lvl = 1'b0;
      settle();
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      if (!done_flag) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_st("R10 reset state", 1, 1, 0, 0);
      por_n = 1'b1;
      settle();
      expect_st("R7 power-up load", 100, 0, 0, 0);
      set_ce(1'b1);
      pulse(1'b0, MINC - 10);
      expect_st("R2 short pulse dropped", 100, 0, 0, 0);
      pulse(1'b0, MINC + 5);
      expect_st("R3 first pulse discarded", 100, 0, 0, 0);
      pulse(1'b0, MINC);
      expect_st("R4 R2 step up at minimum width", 101, 0, 0, 0);
      pulse(1'b0, MINC + 5);
      expect_st("R4 step up again", 102, 0, 0, 0);
      pulse(1'b1, MINC + 5);
      expect_st("R4 step down", 101, 0, 0, 0);
      set_ce(1'b0);
      expect_st("R7 reload on enable fall", 100, 0, 0, 0);
      pulse(1'b0, MINC + 5);
      expect_st("R6 pulse ignored while disabled", 100, 0, 0, 0);
      set_ce(1'b1);
      pulse(1'b0, MINC + 5);
      expect_st("R3 reload does not re-arm discard", 101, 0, 0, 0);
      nv_mem = 8'd127;
      set_ce(1'b0);
      set_ce(1'b1);
      pulse(1'b0, MINC + 5);
      expect_st("R5 up to top", 128, 0, 0, 0);
      pulse(1'b0, MINC + 5);
      expect_st("R5 saturate at 128", 128, 0, 0, 0);
      nv_mem = 8'd2;
      set_ce(1'b0);
      set_ce(1'b1);
      pulse(1'b1, MINC + 5);
      expect_st("R5 down to bottom", 1, 0, 0, 0);
      pulse(1'b1, MINC + 5);
      expect_st("R5 saturate at 1", 1, 0, 0, 0);
      nv_mem = 8'd0;
      set_ce(1'b0);
      expect_st("R1 zero clamps to 1", 1, 0, 0, 0);
      nv_mem = 8'd200;
      set_ce(1'b1);
      set_ce(1'b0);
      expect_st("R1 large clamps to 128", 128, 0, 0, 0);
      nv_mem = 8'd50;
      set_ce(1'b1);
      set_ce(1'b0);
      set_ce(1'b1);
      pulse(1'b0, MINC + 5);
      expect_st("R4 setup before program", 51, 0, 0, 0);
      hold_prog(HOLD - 50);
      expect_st("R8 short hold starts no write", 51, 0, 0, 0);
      hold_prog(HOLD + 50);
      expect_st("R8 write requested", 51, 1, 1, 51);
      pulse(1'b0, MINC + 5);
      expect_st("R9 pulse ignored while busy", 51, 1, 1, 51);
      @(negedge clk);
      nv_mem = nv_wr_data;
      nv_wr_done = 1'b1;
      @(negedge clk);
      nv_wr_done = 1'b0;
      settle();
      expect_st("R9 write completes", 51, 0, 0, 0);
      pulse(1'b0, MINC + 5);
      expect_st("R4 count resumes", 52, 0, 0, 0);
      set_ce(1'b0);
      expect_st("R8 stored value reloaded", 51, 0, 0, 0);
      hold_prog(HOLD + 50);
      expect_st("R8 no write while disabled", 51, 0, 0, 0);
      repeat (3) @(negedge clk);
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule